// File: doc/BRIEF.md
# Accumulator ALU with Decimal-Adjust Flags

This block is the 8-bit accumulator arithmetic and logic unit of a small processor core. Each cycle it takes an operation code, the accumulator value and a second operand. From these and its own flag register it produces a result, a write-enable that tells the register file whether the accumulator is to take that result, and the next value of the four status flags. The result and its write-enable are combinational. The flags are held in a register inside the block and update on the clock edge at which `op_valid_i` is high.

The flag byte has zero (Z) in bit 7, subtract (N) in bit 6, half-carry (H) in bit 5 and carry (C) in bit 4. Bits 3..0 always read as zero. The flag byte can also be loaded whole from the `flag_ld_*` inputs, which is the path used when the flags are restored from the stack. Some operations leave certain flags alone. Those flags keep their prior values. Z is always computed on the 8-bit truncated result.

Top module: `bcd_acc_alu`

## Requirements
- R1: After the asynchronous reset `rst_ni` is asserted, `flags_o` is 0x00.
- R2: Op codes 0 (ADD) and 1 (ADC, which adds C). They write the 8-bit sum with `result_we_o`=1 and clear N. H is set when the low-nibble sum, including carry-in, reaches 0x10. C is set when the full sum reaches 0x100. Z is set when the 8-bit sum is zero.
- R3: Op codes 2 (SUB) and 3 (SBC, which subtracts C). They write the 8-bit difference and set N. H is set on a borrow out of the low nibble, including carry-in. C is set when the full difference is negative.
- R4: Op code 7 (compare) updates the flags exactly as SUB does. It holds `result_we_o` at 0 and drives `result_o` with `acc_i`.
- R5: Op codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result and clear N and C. AND sets H and the other two clear it. Z follows the result.
- R6: Op codes 8 (increment) and 9 (decrement) act on `acc_i` and keep C. Increment clears N and sets H when the old low nibble was 0xF. Decrement sets N and sets H when the old low nibble was 0x0.
- R7: Op code 10 (decimal adjust) with N=0 first adds 0x06 if the low nibble is above 9 or H=1. It then adds 0x60 and sets C if the intermediate high nibble is above 9 or C=1; otherwise it clears C. H is cleared, N is kept and Z follows the result.
- R8: Op code 10 with N=1 adds 0xFA when H=1 and 0xA0 when C=1. C and N are kept, H is cleared and Z follows the result.
- R9: Op code 11 (complement) writes ~`acc_i`, sets H and N, and keeps Z and C. Op code 12 (set carry) sets C. Op code 13 (complement carry) inverts C. Both clear H and N, keep Z, and hold `result_we_o` at 0.
- R10: When `flag_ld_i` is high at a clock edge, the flags become `flag_ld_data_i[7:4]` with bits 3..0 forced to zero. This takes priority over `op_valid_i`.
- R11: The flags change only at an edge where `op_valid_i` or `flag_ld_i` is high. Op codes 14 and 15 keep the flags and hold `result_we_o` at 0.
- R12: `flags_o[3:0]` is zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Update the flags from the current operation at this edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flag_ld_i | input | 1 | Load the flag byte directly |
| flag_ld_data_i | input | 8 | Flag byte to load; low nibble ignored |
| result_o | output | 8 | Combinational result |
| result_we_o | output | 1 | Accumulator write-enable for this operation |
| flags_o | output | 8 | Registered flag byte |

## Verification
The hardest situations to reach are the decimal-adjust branches. Their outcome depends on flags left behind by an earlier operation, and a normal arithmetic sequence only produces some flag combinations. The bench uses the flag-load path to place each exact N/H/C combination, including ones no addition could produce, in the cycle before the adjust. It then covers both carry-out outcomes of the addition branch and each correction of the subtraction branch.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;
  localparam int LO_W   = NIB_W + 1;
  localparam int FULL_W = DATA_W + 1;

  localparam logic [NIB_W-1:0]  DEC_MAX     = NIB_W'(9);
  localparam logic [DATA_W-1:0] ADJ_LO_ADD  = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] ADJ_HI_ADD  = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] ADJ_LO_SUB  = DATA_W'(8'hFA);
  localparam logic [DATA_W-1:0] ADJ_HI_SUB  = DATA_W'(8'hA0);

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBC = 4'd3,
    OP_AND  = 4'd4,  OP_XOR  = 4'd5,  OP_OR   = 4'd6,  OP_CP  = 4'd7,
    OP_INC  = 4'd8,  OP_DEC  = 4'd9,  OP_DAA  = 4'd10, OP_CPL = 4'd11,
    OP_SCF  = 4'd12, OP_CCF  = 4'd13, OP_NOP0 = 4'd14, OP_NOP1 = 4'd15
  } alu_op_e;

  // order matches flag byte bits 7..4
  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith
  import bcd_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  flags_t            fl_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            fl_o
);
  logic              sub, unary, cin;
  logic [DATA_W-1:0] rhs;
  logic [LO_W-1:0]   lo;
  logic [FULL_W-1:0] full;

  always_comb begin
    sub   = op_i inside {OP_SUB, OP_SBC, OP_CP, OP_DEC};
    unary = op_i inside {OP_INC, OP_DEC};
    cin   = (op_i inside {OP_ADC, OP_SBC}) & fl_i.c;
    rhs   = unary ? DATA_W'(1) : b_i;
    if (sub) begin
      lo   = {1'b0, a_i[NIB_W-1:0]} - {1'b0, rhs[NIB_W-1:0]} - LO_W'(cin);
      full = {1'b0, a_i} - {1'b0, rhs} - FULL_W'(cin);
    end else begin
      lo   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, rhs[NIB_W-1:0]} + LO_W'(cin);
      full = {1'b0, a_i} + {1'b0, rhs} + FULL_W'(cin);
    end
    res_o  = full[DATA_W-1:0];
    fl_o.z = ~|full[DATA_W-1:0];
    fl_o.n = sub;
    fl_o.h = lo[NIB_W];
    // inc/dec keep carry
    fl_o.c = unary ? fl_i.c : full[DATA_W];
  end
endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
  import bcd_alu_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  flags_t            fl_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            fl_o
);
  always_comb begin
    res_o = a_i;
    fl_o  = fl_i;
    unique case (op_i)
      OP_AND: begin
        res_o = a_i & b_i;
        fl_o  = '{z: ~|(a_i & b_i), n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_XOR: begin
        res_o = a_i ^ b_i;
        fl_o  = '{z: ~|(a_i ^ b_i), n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_OR: begin
        res_o = a_i | b_i;
        fl_o  = '{z: ~|(a_i | b_i), n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_CPL: begin
        res_o  = ~a_i;
        fl_o.n = 1'b1;
        fl_o.h = 1'b1;
      end
      OP_SCF: begin
        fl_o.n = 1'b0;
        fl_o.h = 1'b0;
        fl_o.c = 1'b1;
      end
      OP_CCF: begin
        fl_o.n = 1'b0;
        fl_o.h = 1'b0;
        fl_o.c = ~fl_i.c;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_alu_daa.sv
module bcd_alu_daa
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  flags_t            fl_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            fl_o
);
  logic              fix_lo, fix_hi;
  logic [DATA_W-1:0] step;

  always_comb begin
    if (fl_i.n) begin
      fix_lo = fl_i.h;
      step   = a_i + (fix_lo ? ADJ_LO_SUB : '0);
      fix_hi = fl_i.c;
      res_o  = step + (fix_hi ? ADJ_HI_SUB : '0);
    end else begin
      fix_lo = (a_i[NIB_W-1:0] > DEC_MAX) | fl_i.h;
      step   = a_i + (fix_lo ? ADJ_LO_ADD : '0);
      // high-nibble test sees the low-corrected value
      fix_hi = (step[DATA_W-1:NIB_W] > DEC_MAX) | fl_i.c;
      res_o  = step + (fix_hi ? ADJ_HI_ADD : '0);
    end
    fl_o.z = ~|res_o;
    fl_o.n = fl_i.n;
    fl_o.h = 1'b0;
    fl_o.c = fl_i.n ? fl_i.c : fix_hi;
  end
endmodule

// File: rtl/bcd_alu_flag_reg.sv
module bcd_alu_flag_reg
  import bcd_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  flags_t            d_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output flags_t            q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= flags_t'(ld_data_i[DATA_W-1 -: FLAG_W]);
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/bcd_acc_alu.sv
module bcd_acc_alu
  import bcd_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              flag_ld_i,
  input  logic [DATA_W-1:0] flag_ld_data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_we_o,
  output logic [DATA_W-1:0] flags_o
);
  alu_op_e           op;
  flags_t            fl_cur, fl_nxt, fl_ar, fl_lg, fl_da;
  logic [DATA_W-1:0] res_ar, res_lg, res_da;

  assign op = alu_op_e'(op_i);

  bcd_alu_arith u_arith (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .fl_i(fl_cur), .res_o(res_ar), .fl_o(fl_ar)
  );

  bcd_alu_logic u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .fl_i(fl_cur), .res_o(res_lg), .fl_o(fl_lg)
  );

  bcd_alu_daa u_daa (
    .a_i(acc_i), .fl_i(fl_cur), .res_o(res_da), .fl_o(fl_da)
  );

  always_comb begin
    result_o    = acc_i;
    fl_nxt      = fl_cur;
    result_we_o = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
        result_o    = res_ar;
        fl_nxt      = fl_ar;
        result_we_o = 1'b1;
      end
      OP_CP: fl_nxt = fl_ar;
      OP_AND, OP_XOR, OP_OR, OP_CPL: begin
        result_o    = res_lg;
        fl_nxt      = fl_lg;
        result_we_o = 1'b1;
      end
      OP_SCF, OP_CCF: fl_nxt = fl_lg;
      OP_DAA: begin
        result_o    = res_da;
        fl_nxt      = fl_da;
        result_we_o = 1'b1;
      end
      default: ;
    endcase
  end

  bcd_alu_flag_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(op_valid_i), .d_i(fl_nxt),
    .ld_i(flag_ld_i), .ld_data_i(flag_ld_data_i), .q_o(fl_cur)
  );

  assign flags_o = {fl_cur, {(DATA_W-FLAG_W){1'b0}}};
endmodule

// File: rtl/bcd_acc_alu_chk.sv
module bcd_acc_alu_chk
  import bcd_alu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic              flag_ld_i,
  input logic [DATA_W-1:0] flag_ld_data_i,
  input logic              result_we_o,
  input logic [DATA_W-1:0] flags_o
);
  // R12
  low_nibble_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'h0);

  // R4
  compare_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CP) |-> !result_we_o);

  // R11
  idle_flags_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !flag_ld_i) |=> $stable(flags_o));

  // R10
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_ld_i |=> flags_o == {$past(flag_ld_data_i[7:4]), 4'h0});

  // R6
  incdec_keep_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !flag_ld_i && (op_i == OP_INC || op_i == OP_DEC))
      |=> flags_o[4] == $past(flags_o[4]));

  // R9
  set_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !flag_ld_i && op_i == OP_SCF) |=> flags_o[6:4] == 3'b001);
endmodule

bind bcd_acc_alu bcd_acc_alu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
  .flag_ld_i(flag_ld_i), .flag_ld_data_i(flag_ld_data_i),
  .result_we_o(result_we_o), .flags_o(flags_o)
);

// File: tb/bcd_acc_alu_tb.sv
module bcd_acc_alu_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [3:0] op_i = 4'd14;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       flag_ld_i = 1'b0;
  logic [7:0] flag_ld_data_i = '0;
  logic [7:0] result_o, flags_o;
  logic       result_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  bcd_acc_alu u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // reference from the requirement text: {we, result, flags}
  function automatic logic [16:0] ref_alu(input logic [3:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] f);
    logic z, n, h, c, we, fl, fh;
    logic [7:0] r, s;
    int t, ci;
    z = f[7]; n = f[6]; h = f[5]; c = f[4]; r = a; we = 1'b0;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1) ? int'(c) : 0;
        t = int'(a) + int'(b) + ci;
        h = (int'(a & 8'h0F) + int'(b & 8'h0F) + ci) >= 16;
        c = t >= 256; n = 1'b0; r = t[7:0]; z = (r == 0); we = 1'b1;
      end
      4'd2, 4'd3, 4'd7: begin
        ci = (op == 4'd3) ? int'(c) : 0;
        t = int'(a) - int'(b) - ci;
        h = (int'(a & 8'h0F) - int'(b & 8'h0F) - ci) < 0;
        c = t < 0; n = 1'b1; z = (t[7:0] == 0);
        if (op != 4'd7) begin r = t[7:0]; we = 1'b1; end
      end
      4'd4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; we = 1; end
      4'd5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
      4'd6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; end
      4'd8: begin h = (a[3:0] == 4'hF); r = a + 8'd1; n = 0; z = (r == 0); we = 1; end
      4'd9: begin h = (a[3:0] == 4'h0); r = a - 8'd1; n = 1; z = (r == 0); we = 1; end
      4'd10: begin
        if (n) begin
          r = a;
          if (h) r = r + 8'hFA;
          if (c) r = r + 8'hA0;
        end else begin
          fl = (a[3:0] > 4'd9) || h;
          s = fl ? a + 8'h06 : a;
          fh = (s[7:4] > 4'd9) || c;
          r = fh ? s + 8'h60 : s;
          c = fh;
        end
        h = 0; z = (r == 0); we = 1;
      end
      4'd11: begin r = ~a; h = 1; n = 1; we = 1; end
      4'd12: begin c = 1; h = 0; n = 0; end
      4'd13: begin c = ~c; h = 0; n = 0; end
      default: ;
    endcase
    return {we, r, z, n, h, c, 4'h0};
  endfunction

  task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] pre);
    logic [16:0] e;
    @(negedge clk_i);
    flag_ld_i = 1'b1; flag_ld_data_i = pre; op_valid_i = 1'b0;
    @(negedge clk_i);
    flag_ld_i = 1'b0; op_i = op; acc_i = a; opnd_i = b; op_valid_i = 1'b1;
    e = ref_alu(op, a, b, pre & 8'hF0);
    #1;
    chk({req, " we"}, {7'd0, result_we_o}, {7'd0, e[16]});
    chk({req, " result"}, result_o, e[15:8]);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk({req, " flags"}, flags_o, e[7:0]);
  endtask

  task automatic t_reset;
    chk("R1 reset flags", flags_o, 8'h00);
  endtask

  task automatic t_add;
    run_op("R2 add wrap", 4'd0, 8'h3A, 8'hC6, 8'h00);
    chk("R2 add wrap flags", flags_o, 8'hB0);
    run_op("R2 adc half", 4'd1, 8'h0F, 8'h00, 8'h10);
    chk("R2 adc half flags", flags_o, 8'h20);
    run_op("R2 adc no c", 4'd1, 8'h7F, 8'h01, 8'h00);
  endtask

  task automatic t_sub;
    run_op("R3 sub zero", 4'd2, 8'h3E, 8'h3E, 8'h00);
    chk("R3 sub zero flags", flags_o, 8'hC0);
    run_op("R3 sub borrow", 4'd2, 8'h10, 8'h01, 8'h00);
    run_op("R3 sbc carry", 4'd3, 8'h00, 8'h00, 8'h10);
    chk("R3 sbc flags", flags_o, 8'h70);
    run_op("R4 compare", 4'd7, 8'h3C, 8'h40, 8'h00);
    chk("R4 compare flags", flags_o, 8'h50);
  endtask

  task automatic t_logic;
    run_op("R5 and", 4'd4, 8'h5A, 8'hA5, 8'h50);
    chk("R5 and flags", flags_o, 8'hA0);
    run_op("R5 xor", 4'd5, 8'hFF, 8'h0F, 8'hF0);
    run_op("R5 or", 4'd6, 8'h00, 8'h00, 8'h70);
  endtask

  task automatic t_incdec;
    run_op("R6 inc wrap", 4'd8, 8'hFF, 8'h00, 8'h10);
    chk("R6 inc flags", flags_o, 8'hB0);
    run_op("R6 dec nib", 4'd9, 8'h10, 8'h00, 8'h00);
    run_op("R6 dec zero", 4'd9, 8'h01, 8'h00, 8'h10);
  endtask

  task automatic t_daa;
    run_op("R7 daa lo", 4'd10, 8'h7D, 8'h00, 8'h00);
    chk("R7 daa lo result", result_o, 8'h83);
    run_op("R7 daa both", 4'd10, 8'h9A, 8'h00, 8'h00);
    chk("R7 daa both flags", flags_o, 8'h90);
    run_op("R7 daa c in", 4'd10, 8'h00, 8'h00, 8'h10);
    run_op("R7 daa h in", 4'd10, 8'h42, 8'h00, 8'h20);
    run_op("R8 daa sub h", 4'd10, 8'h1F, 8'h00, 8'h60);
    chk("R8 daa sub h flags", flags_o, 8'h40);
    run_op("R8 daa sub hc", 4'd10, 8'h5A, 8'h00, 8'h70);
    run_op("R8 daa sub c", 4'd10, 8'hA0, 8'h00, 8'h50);
  endtask

  task automatic t_misc;
    run_op("R9 cpl", 4'd11, 8'h35, 8'h00, 8'h90);
    chk("R9 cpl flags", flags_o, 8'hF0);
    run_op("R9 scf", 4'd12, 8'h35, 8'h00, 8'hE0);
    chk("R9 scf flags", flags_o, 8'h90);
    run_op("R9 ccf set", 4'd13, 8'h35, 8'h00, 8'h70);
    run_op("R9 ccf clr", 4'd13, 8'h35, 8'h00, 8'h00);
  endtask

  task automatic t_load_idle;
    // R10 load with low nibble set and op_valid high
    @(negedge clk_i);
    flag_ld_i = 1'b1; flag_ld_data_i = 8'hAF; op_valid_i = 1'b1; op_i = 4'd12;
    @(negedge clk_i);
    flag_ld_i = 1'b0; op_valid_i = 1'b0;
    chk("R10 load priority", flags_o, 8'hA0);
    chk("R12 low nibble", {4'h0, flags_o[3:0]}, 8'h00);
    // R11 op present but not valid
    op_i = 4'd13; acc_i = 8'h00;
    @(negedge clk_i);
    chk("R11 idle", flags_o, 8'hA0);
    run_op("R11 code14", 4'd14, 8'h12, 8'h34, 8'h50);
    chk("R11 code14 flags", flags_o, 8'h50);
    run_op("R11 code15", 4'd15, 8'h00, 8'h00, 8'hF0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #9;
    t_reset();
    rst_ni = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_daa();
    t_misc();
    t_load_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule